// File: doc/BRIEF.md
# Output Fault Manager with Retry

This block is the protection controller for a four-channel switching output stage arranged as two channel pairs. Each pair passes its two PWM inputs to its outputs while it is healthy. It switches both outputs of the pair off (drive enable low, which an output stage reads as high impedance) when the pair sees an over-current on either of its channels. Over-temperature and supply under-voltage are shared conditions, and each of them is a fault on both pairs. Depending on a three-bit strap value captured when a pair leaves reset, a faulted pair either stays off until its reset is cycled, or retries on its own at a fixed interval. In the retry case it gives up and stays off after a set number of failed attempts. The strap value also selects whether the second input of every pair is inverted internally, so that one PWM signal can drive both halves of a full bridge.

Three kinds of active-low, wire-OR-able error flags come out of the block: one over-current flag per pair, one combined over-temperature/under-voltage flag, and one thermal-warning flag. The retry interval is derived from a clock-frequency parameter through a millisecond prescaler, so a short interval can be used for simulation.

Top module: `drv_fault_guard`

## Requirements
- R1: Strap bit 0 selects latched shutdown (1) or auto-retry (0), and strap bit 1 selects inversion of the second channel of each pair. So 000, 001, 010 and 011 are the four legal modes. Any strap with bit 2 set is reserved. A pair that leaves reset under a reserved strap keeps its outputs disabled, and while the live strap has bit 2 set every error flag stays high.
- R2: A pair captures the strap in the first clock after its active-low reset is seen high. A strap change while that reset stays high has no effect on the pair's behaviour.
- R3: While a pair reset is low, both outputs of that pair have drive enable low and data 0, and any retry count is discarded. After the global synchronous reset, all drive enables are low and all flags are high.
- R4: An enabled pair registers its inputs to its outputs with one clock of latency. In the inverting modes the odd-numbered channel (bits 1 and 3) is the inverse of its input.
- R5: An over-current on either channel of a pair, or over-temperature, or under-voltage, sampled while the pair is enabled, drops that pair's drive enables at the same clock edge. An over-current on one pair leaves the other pair enabled.
- R6: In latched mode a faulted pair stays disabled, whether or not the fault clears, until its reset goes low and then high again.
- R7: In auto-retry mode the pair re-checks the fault exactly CLK_HZ/1000*RETRY_MS clocks after the edge that disabled it. If no fault is present at that edge it re-enables there; otherwise it waits another full interval.
- R8: In auto-retry mode the MAX_TRIES-th consecutive failed re-check latches the pair off until its reset is cycled. A re-check that succeeds before that limit restores normal operation.
- R9: The over-current flag of pair p goes low one clock after either channel 2p or 2p+1 reports over-current, and is high otherwise. This flag is independent of the pair reset.
- R10: The warning flag goes low one clock after the thermal-warning input is high. The combined error flag goes low one clock after over-temperature or under-voltage is high. Each flag is high otherwise.
- R11: A channel whose drive enable was low before an edge outputs data 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| pair_rst_n | input | NPAIRS | Active-low reset per channel pair |
| mode_strap | input | 3 | Mode straps: bit0 latch, bit1 invert, bit2 reserved |
| pwm_in | input | 2*NPAIRS | PWM inputs, channel 2p and 2p+1 form pair p |
| oc_chan | input | 2*NPAIRS | Over-current indication per channel |
| therm_warn | input | 1 | Thermal warning threshold exceeded |
| over_temp | input | 1 | Over-temperature condition |
| under_volt | input | 1 | Supply under-voltage condition |
| pwm_out | output | 2*NPAIRS | Registered PWM outputs |
| out_en | output | 2*NPAIRS | Per-channel drive enable, low means high impedance |
| oc_err_n | output | NPAIRS | Active-low over-current flag per pair |
| uvt_err_n | output | 1 | Active-low over-temperature or under-voltage flag |
| warn_n | output | 1 | Active-low thermal warning flag |

## Verification
The sharpest same-cycle collision is a retry re-check landing on the very edge where a fault reappears. The bench clears a fault for all of the interval except the single clock before the re-check edge. It then expects the attempt to count as failed, with the pair still off, and a recovery exactly one interval later. A second collision is a persistent fault meeting the final allowed attempt. Here the fault is held through four re-checks and released just before the fifth, and the pair must recover. When the fault is held through all five, the pair must stay off after the fault clears. Flag reporting and output disabling happen on the same edge for every fault input, and a full sweep of the fault inputs checks the flags independently of the retry state.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [2:0] {
    PS_OFF  = 3'd0,
    PS_RUN  = 3'd1,
    PS_WAIT = 3'd2,
    PS_LOCK = 3'd3,
    PS_HOLD = 3'd4
  } pair_state_e;

  typedef struct packed {
    logic reserved;
    logic invert;
    logic latched;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_strap(input logic [2:0] s);
    mode_cfg_t c;
    c.reserved = s[2];
    c.invert   = s[1] & ~s[2];
    c.latched  = s[0] & ~s[2];
    return c;
  endfunction

endpackage

// File: rtl/pfg_retry_timer.sv
module pfg_retry_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int RETRY_MS   = 85
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expire
);
  localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam int MW = (RETRY_MS > 1) ? $clog2(RETRY_MS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_MS - 1);
  localparam logic [MW-1:0] MS_LAST  = MW'(RETRY_MS - 1);

  logic [PW-1:0] pre_q;
  logic [MW-1:0] ms_q;
  logic          pre_wrap;
  logic          ms_wrap;

  assign pre_wrap = (pre_q == PRE_LAST);
  assign ms_wrap  = (ms_q == MS_LAST);
  assign expire   = ~clear & pre_wrap & ms_wrap;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      ms_q  <= ms_wrap ? '0 : ms_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/pfg_pair_ctrl.sv
module pfg_pair_ctrl
  import pfg_pkg::*;
#(
  parameter int CYC_PER_MS = 100000,
  parameter int RETRY_MS   = 85,
  parameter int MAX_TRIES  = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pair_rst_n,
  input  logic [2:0] mode_strap,
  input  logic       fault,
  input  logic [1:0] pwm_in,
  output logic [1:0] pwm_out,
  output logic       drive_en
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES - 1);

  pair_state_e   state_q;
  mode_cfg_t     cfg_q;
  mode_cfg_t     cfg_new;
  logic [TW-1:0] tries_q;
  logic          expire;
  logic          tmr_clear;

  assign cfg_new   = decode_strap(mode_strap);
  assign tmr_clear = (state_q != PS_WAIT) | ~pair_rst_n;
  assign drive_en  = (state_q == PS_RUN);

  pfg_retry_timer #(
    .CYC_PER_MS(CYC_PER_MS),
    .RETRY_MS  (RETRY_MS)
  ) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clear),
    .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_OFF;
      cfg_q   <= '0;
      tries_q <= '0;
    end else if (!pair_rst_n) begin
      state_q <= PS_OFF;
      tries_q <= '0;
    end else begin
      unique case (state_q)
        PS_OFF: begin
          cfg_q   <= cfg_new;
          tries_q <= '0;
          state_q <= cfg_new.reserved ? PS_HOLD : PS_RUN;
        end
        PS_RUN: begin
          if (fault) begin
            tries_q <= '0;
            state_q <= cfg_q.latched ? PS_LOCK : PS_WAIT;
          end
        end
        PS_WAIT: begin
          if (expire) begin
            if (!fault) begin
              tries_q <= '0;
              state_q <= PS_RUN;
            end else if (tries_q == TRY_LAST) begin
              state_q <= PS_LOCK;
            end else begin
              tries_q <= tries_q + 1'b1;
            end
          end
        end
        PS_LOCK: state_q <= PS_LOCK;
        PS_HOLD: state_q <= PS_HOLD;
        default: state_q <= PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= '0;
    end else if (drive_en) begin
      pwm_out <= {pwm_in[1] ^ cfg_q.invert, pwm_in[0]};
    end else begin
      pwm_out <= '0;
    end
  end
endmodule

// File: rtl/pfg_flag_out.sv
module pfg_flag_out #(
  parameter int NPAIRS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  quiet,
  input  logic [2*NPAIRS-1:0]   oc_chan,
  input  logic                  therm_warn,
  input  logic                  over_temp,
  input  logic                  under_volt,
  output logic [NPAIRS-1:0]     oc_err_n,
  output logic                  uvt_err_n,
  output logic                  warn_n
);
  logic [NPAIRS-1:0] oc_pair;

  for (genvar p = 0; p < NPAIRS; p++) begin : g_or
    assign oc_pair[p] = |oc_chan[2*p +: 2];
  end

  always_ff @(posedge clk) begin
    if (rst || quiet) begin
      oc_err_n  <= '1;
      uvt_err_n <= 1'b1;
      warn_n    <= 1'b1;
    end else begin
      oc_err_n  <= ~oc_pair;
      uvt_err_n <= ~(over_temp | under_volt);
      warn_n    <= ~therm_warn;
    end
  end
endmodule

// File: rtl/drv_fault_guard.sv
module drv_fault_guard #(
  parameter int NPAIRS    = 2,
  parameter int CLK_HZ    = 100000000,
  parameter int RETRY_MS  = 85,
  parameter int MAX_TRIES = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPAIRS-1:0]     pair_rst_n,
  input  logic [2:0]            mode_strap,
  input  logic [2*NPAIRS-1:0]   pwm_in,
  input  logic [2*NPAIRS-1:0]   oc_chan,
  input  logic                  therm_warn,
  input  logic                  over_temp,
  input  logic                  under_volt,
  output logic [2*NPAIRS-1:0]   pwm_out,
  output logic [2*NPAIRS-1:0]   out_en,
  output logic [NPAIRS-1:0]     oc_err_n,
  output logic                  uvt_err_n,
  output logic                  warn_n
);
  localparam int CYC_PER_MS = (CLK_HZ >= 1000) ? CLK_HZ / 1000 : 1;

  logic shared_fault;
  assign shared_fault = over_temp | under_volt;

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    logic en;
    logic fault;
    assign fault = (|oc_chan[2*p +: 2]) | shared_fault;

    pfg_pair_ctrl #(
      .CYC_PER_MS(CYC_PER_MS),
      .RETRY_MS  (RETRY_MS),
      .MAX_TRIES (MAX_TRIES)
    ) u_pair (
      .clk       (clk),
      .rst       (rst),
      .pair_rst_n(pair_rst_n[p]),
      .mode_strap(mode_strap),
      .fault     (fault),
      .pwm_in    (pwm_in[2*p +: 2]),
      .pwm_out   (pwm_out[2*p +: 2]),
      .drive_en  (en)
    );
    assign out_en[2*p +: 2] = {en, en};
  end

  pfg_flag_out #(.NPAIRS(NPAIRS)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .quiet     (mode_strap[2]),
    .oc_chan   (oc_chan),
    .therm_warn(therm_warn),
    .over_temp (over_temp),
    .under_volt(under_volt),
    .oc_err_n  (oc_err_n),
    .uvt_err_n (uvt_err_n),
    .warn_n    (warn_n)
  );
endmodule

// File: rtl/drv_fault_guard_chk.sv
module drv_fault_guard_chk #(
  parameter int NPAIRS = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NPAIRS-1:0]     pair_rst_n,
  input logic [2:0]            mode_strap,
  input logic [2*NPAIRS-1:0]   oc_chan,
  input logic                  therm_warn,
  input logic                  over_temp,
  input logic                  under_volt,
  input logic [2*NPAIRS-1:0]   pwm_out,
  input logic [2*NPAIRS-1:0]   out_en,
  input logic [NPAIRS-1:0]     oc_err_n,
  input logic                  uvt_err_n,
  input logic                  warn_n
);
  for (genvar p = 0; p < NPAIRS; p++) begin : g_p
    // R5
    a_r5_fault_drops_enable: assert property (@(posedge clk) disable iff (rst)
      (out_en[2*p] && pair_rst_n[p] &&
       ((|oc_chan[2*p +: 2]) || over_temp || under_volt)) |=> !out_en[2*p]);
    // R3
    a_r3_pair_reset_off: assert property (@(posedge clk) disable iff (rst)
      !pair_rst_n[p] |=> (!out_en[2*p] && !out_en[2*p+1]));
    // R9
    a_r9_oc_flag: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(mode_strap[2])) |->
        (oc_err_n[p] == !$past(|oc_chan[2*p +: 2])));
  end

  for (genvar c = 0; c < 2*NPAIRS; c++) begin : g_c
    // R11
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(out_en[c])) |-> !pwm_out[c]);
  end

  // R1
  a_r1_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_strap[2])) |-> ((&oc_err_n) && uvt_err_n && warn_n));
  // R10
  a_r10_thermal_flags: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_strap[2])) |->
      (warn_n == !$past(therm_warn) && uvt_err_n == !$past(over_temp || under_volt)));
endmodule

bind drv_fault_guard drv_fault_guard_chk #(.NPAIRS(NPAIRS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pair_rst_n(pair_rst_n),
  .mode_strap(mode_strap),
  .oc_chan   (oc_chan),
  .therm_warn(therm_warn),
  .over_temp (over_temp),
  .under_volt(under_volt),
  .pwm_out   (pwm_out),
  .out_en    (out_en),
  .oc_err_n  (oc_err_n),
  .uvt_err_n (uvt_err_n),
  .warn_n    (warn_n)
);

// File: tb/sim_drv_fault_guard.sv
`timescale 1ns/1ps
module sim_drv_fault_guard;
  localparam int CLK_HZ = 4000;
  localparam int RMS    = 3;
  localparam int TRIES  = 5;
  localparam int R      = (CLK_HZ / 1000) * RMS;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] pair_rst_n;
  logic [2:0] mode_strap;
  logic [3:0] pwm_in;
  logic [3:0] oc_chan;
  logic       therm_warn, over_temp, under_volt;
  logic [3:0] pwm_out, out_en;
  logic [1:0] oc_err_n;
  logic       uvt_err_n, warn_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  drv_fault_guard #(.NPAIRS(2), .CLK_HZ(CLK_HZ), .RETRY_MS(RMS), .MAX_TRIES(TRIES)) u0 (
    .clk(clk), .rst(rst), .pair_rst_n(pair_rst_n), .mode_strap(mode_strap),
    .pwm_in(pwm_in), .oc_chan(oc_chan), .therm_warn(therm_warn),
    .over_temp(over_temp), .under_volt(under_volt), .pwm_out(pwm_out),
    .out_en(out_en), .oc_err_n(oc_err_n), .uvt_err_n(uvt_err_n), .warn_n(warn_n)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart(input logic [2:0] m);
    pair_rst_n = 2'b00;
    mode_strap = m;
    step();
    pair_rst_n = 2'b11;
    step();
  endtask

  function automatic logic [3:0] flags_now();
    return {oc_err_n, uvt_err_n, warn_n};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pair_rst_n = 2'b00; mode_strap = 3'b000; pwm_in = '0;
    oc_chan = '0; therm_warn = 0; over_temp = 0; under_volt = 0;
    step(3);
    // R3 reset state
    check("R3 reset enables", out_en, 4'h0);
    check("R3 reset data", pwm_out, 4'h0);
    check("R3 reset flags", flags_now(), 4'hF);
    rst = 1'b0;
    step();

    // R1 R4: every legal mode, every input pattern
    for (int m = 0; m < 4; m++) begin
      restart(3'(m));
      check("R1 enabled after load", out_en, 4'hF);
      for (int v = 0; v < 16; v++) begin
        pwm_in = 4'(v);
        step();
        check("R4 passthrough", pwm_out, 4'(v) ^ ((m & 2) != 0 ? 4'b1010 : 4'b0000));
      end
    end

    // R2: strap change while running is ignored
    restart(3'b000);
    mode_strap = 3'b011;
    pwm_in = 4'b1111; step(2);
    check("R2 no inversion after strap change", pwm_out, 4'b1111);
    oc_chan = 4'b0001; step(); oc_chan = 0; step(R + 1);
    check("R2 still auto-retry", out_en, 4'hF);
    mode_strap = 3'b000;

    // R1 reserved codes
    for (int m = 4; m < 8; m++) begin
      pair_rst_n = 2'b00; mode_strap = 3'(m); step();
      pair_rst_n = 2'b11; oc_chan = 4'hF; therm_warn = 1; under_volt = 1; pwm_in = 4'hF;
      step(2);
      check("R1 reserved enables", out_en, 4'h0);
      check("R1 reserved data", pwm_out, 4'h0);
      check("R1 reserved flags", flags_now(), 4'hF);
      oc_chan = 0; therm_warn = 0; under_volt = 0;
    end

    // R9 R10: flag sweep with pairs held in reset
    pair_rst_n = 2'b00; mode_strap = 3'b000; step();
    for (int v = 0; v < 128; v++) begin
      logic [6:0] b;
      b = 7'(v);
      oc_chan = b[3:0]; therm_warn = b[4]; over_temp = b[5]; under_volt = b[6];
      step();
      check("R9 R10 flags", flags_now(),
            {~(b[3] | b[2]), ~(b[1] | b[0]), ~(b[5] | b[6]), ~b[4]});
      check("R3 held off", out_en, 4'h0);
    end
    oc_chan = 0; therm_warn = 0; over_temp = 0; under_volt = 0;

    // R6 R5: latched shutdown, pair independence
    restart(3'b001);
    oc_chan = 4'b0010; step(); oc_chan = 0;
    check("R5 pair0 off, pair1 on", out_en, 4'b1100);
    step(3 * R);
    check("R6 stays latched", out_en, 4'b1100);
    pair_rst_n = 2'b10; step(); pair_rst_n = 2'b11; step();
    check("R6 reset cycle restores", out_en, 4'hF);

    // R7: single retry interval
    restart(3'b000);
    oc_chan = 4'b0100; step(); oc_chan = 0;
    check("R5 other pair kept", out_en[1:0], 2'b11);
    begin
      int n = 0;
      while (out_en[2] == 1'b0 && n < 200) begin step(); n++; end
      check("R7 retry interval", n, R);
    end

    // R5 R7 R10: over-temperature hits both pairs
    over_temp = 1; step(); over_temp = 0;
    check("R5 shared fault", out_en, 4'h0);
    check("R10 error flag", {uvt_err_n, warn_n}, 2'b01);
    step(R);
    check("R7 both pairs back", out_en, 4'hF);

    // R8: persistent fault latches after MAX_TRIES
    under_volt = 1; step(); step(TRIES * R + 2);
    check("R8 off while faulted", out_en, 4'h0);
    under_volt = 0; step(3 * R);
    check("R8 locked after tries", out_en, 4'h0);
    restart(3'b000);
    check("R8 reset cycle restores", out_en, 4'hF);

    // R8 boundary: recover on last allowed attempt
    oc_chan = 4'b0001; step(); step((TRIES - 1) * R); oc_chan = 0;
    step(R - 1);
    check("R8 still waiting", out_en[1:0], 2'b00);
    step();
    check("R8 recovers at last attempt", out_en[1:0], 2'b11);

    // R7: fault reappears exactly on the re-check edge
    oc_chan = 4'b0001; step(); oc_chan = 0;
    step(R - 1);
    oc_chan = 4'b0001; step(); oc_chan = 0;
    check("R7 attempt failed", out_en[1:0], 2'b00);
    step(R - 1);
    check("R7 waiting again", out_en[1:0], 2'b00);
    step();
    check("R7 next attempt succeeds", out_en[1:0], 2'b11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule